// File: doc/BRIEF.md
# Dual Programmable-Length PN Code Generator

This block holds two independent pseudo-noise code generators for a time-division-duplex direct-sequence radio link. One generator produces the spreading code for the transmit half of each duplex cycle. The other produces the despreading code for the receive half. Each generator is a 13-stage linear feedback shift register. A chip counter runs beside it and restarts the register at a power-of-two boundary, so a code of n active stages repeats every 2^n chips. That is one chip longer than a maximal-length sequence. A thermometer length mask selects n, and a 13-bit tap polynomial sets the feedback.

The generators advance only on chip strobes that come from outside the block. A free-running strobe comes from the chip-rate divider and a second strobe comes from the phase-control loop. A master/slave input decides which strobe steps each generator. A configuration-load command takes new polynomials and masks for both generators on the same clock and restarts them. A resync command restarts both generators without changing their configuration. Each generator raises an epoch flag for the first chip of its period.

A single code pin carries the transmit code while the duplex phase input is high and the receive code while it is low. It is held low when the output is disabled. Each time the driven value has to change, the output stops driving for exactly one master clock. A two-state machine tracks this. In state DRIVE it drives the held value and leaves for GAP when the selected value differs from it (transition DRIVE_TO_GAP). In state GAP it releases the pin, captures the new value and always returns to DRIVE (transition GAP_TO_DRIVE). While the values match, DRIVE holds (transition DRIVE_HOLD).

Top module: `pn_code_pair`

## Requirements
- R1: After reset both generators hold the all-ones state with their chip counters at zero, both epoch flags are high, the configuration registers are zero, and the output is in DRIVE with code_out low.
- R2: The active stage mask is {len_mask, 5'b11111}. A thermometer length mask with k ones gives a period of 2^(5+k) chips: 8'h01 gives 64 chips, 8'h03 gives 128 and 8'hFF gives 8192.
- R3: On a step, if every active bit of the chip counter is one, the register reloads all ones and the counter goes to zero. Otherwise bit 0 takes the XOR of the state bits selected by both the polynomial and the active mask, every other bit takes the bit below it, and the counter increments. The code bit is the state bit at the highest active stage.
- R4: A generator's epoch flag is high exactly while its chip counter is zero. It therefore lasts one chip and recurs once per period.
- R5: A pulse on force_load copies both polynomials and both length masks into the generators on the same clock and restarts both generators at the all-ones state. Changes on the polynomial and mask inputs have no effect at any other time.
- R6: A pulse on resync restarts both generators at the all-ones state with counter zero and keeps their configuration. force_load takes priority over resync, and both take priority over a step in the same clock.
- R7: With is_master high, the transmit generator steps on free_stb and the receive generator steps on phase_stb. With is_master low, both step on phase_stb and free_stb has no effect.
- R8: The selected code value is low when out_en is low. Otherwise it is the transmit code bit when tx_half is high and the receive code bit when tx_half is low.
- R9: When the selected value differs from the driven value, code_drive is low for exactly the next master clock. After that clock code_drive is high again and code_out carries the new value.
- R10: While the selected value equals the driven value, code_drive stays high and code_out does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| free_stb | input | 1 | Free-running chip strobe, one clock wide |
| phase_stb | input | 1 | Phase-controlled chip strobe, one clock wide |
| is_master | input | 1 | 1 = master stepping, 0 = slave stepping |
| force_load | input | 1 | Load both configurations and restart both generators |
| resync | input | 1 | Restart both generators at the start state |
| tx_poly | input | 13 | Transmit tap polynomial, bit 0 = first tap |
| rx_poly | input | 13 | Receive tap polynomial, bit 0 = first tap |
| tx_len | input | 8 | Transmit thermometer length mask (stages 5..12) |
| rx_len | input | 8 | Receive thermometer length mask (stages 5..12) |
| tx_half | input | 1 | Duplex phase: 1 = transmit half, 0 = receive half |
| out_en | input | 1 | Code output enable |
| code_out | output | 1 | Shared code value |
| code_drive | output | 1 | 1 = code_out is driven, 0 = pin released |
| tx_epoch | output | 1 | Transmit generator is on the first chip of its period |
| rx_epoch | output | 1 | Receive generator is on the first chip of its period |

## Verification
The situation hardest to reach from the ports is the wrap of the longest code. The epoch flag has to return after exactly 8192 steps, which needs thousands of strobes at a known spacing and a full-length configuration. The stimulus loads mask 8'hFF and drives 8194 free-running strobes. Every chip is compared against a reference model of the recurrence, so the wrap and the restart state are both checked. The one-clock release is reached by changing out_en or tx_half while the two codes differ. It is then sampled on the next two clocks. Toggling tx_half while the codes match shows that no release occurs.

// File: rtl/pn_pkg.sv
package pn_pkg;

    // Shared code output controller states
    typedef enum logic {
        OUT_DRIVE = 1'b0,
        OUT_GAP   = 1'b1
    } out_state_e;

endpackage

// File: rtl/pn_lfsr_gen.sv
module pn_lfsr_gen #(
    parameter int STAGES = 13,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cfg,
    input  logic              restart,
    input  logic              step,
    input  logic [STAGES-1:0] poly_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic              code_bit,
    output logic              epoch
);

    localparam int FIXED = STAGES - LEN_W;
    localparam int IDX_W = $clog2(STAGES);

    logic [STAGES-1:0] poly_q;
    logic [LEN_W-1:0]  len_q;
    logic [STAGES-1:0] state_q;
    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] act_mask;
    logic              last_chip;
    logic              fb;
    logic [IDX_W-1:0]  top_idx;

    assign act_mask  = {len_q, {FIXED{1'b1}}};
    assign last_chip = &(cnt_q | ~act_mask);
    assign fb        = ^(state_q & poly_q & act_mask);

    // highest active stage supplies the code bit
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < STAGES; i++) begin
            if (act_mask[i]) top_idx = IDX_W'(i);
        end
    end

    assign code_bit = state_q[top_idx];
    assign epoch    = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poly_q  <= '0;
            len_q   <= '0;
            state_q <= '1;
            cnt_q   <= '0;
        end else if (load_cfg) begin
            poly_q  <= poly_in;
            len_q   <= len_in;
            state_q <= '1;
            cnt_q   <= '0;
        end else if (restart) begin
            state_q <= '1;
            cnt_q   <= '0;
        end else if (step) begin
            if (last_chip) begin
                state_q <= '1;
                cnt_q   <= '0;
            end else begin
                state_q <= {state_q[STAGES-2:0], fb};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // R2: chip counter never leaves the selected length
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q & ~act_mask) == '0);

    // R6: restart lands on the all-ones start state with epoch raised
    a_r6_restart_start: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cfg || restart) |=> (state_q == '1 && epoch));

    // R3: no step, no change of sequence position
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_cfg || restart || step) |=> ($stable(state_q) && $stable(cnt_q)));

    // R5: configuration moves only on a load
    a_r5_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_cfg |=> ($stable(poly_q) && $stable(len_q)));

endmodule

// File: rtl/pn_out_mux.sv
module pn_out_mux
    import pn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_bit,
    input  logic rx_bit,
    input  logic tx_half,
    input  logic out_en,
    output logic code_out,
    output logic code_drive
);

    out_state_e state_q;
    out_state_e state_d;
    logic       val_q;
    logic       val_d;
    logic       target;

    assign target = out_en & (tx_half ? tx_bit : rx_bit);

    // next state
    always_comb begin
        state_d = state_q;
        val_d   = val_q;
        unique case (state_q)
            OUT_DRIVE: begin
                if (target != val_q) state_d = OUT_GAP;
            end
            OUT_GAP: begin
                state_d = OUT_DRIVE;
                val_d   = target;
            end
            default: state_d = OUT_DRIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_DRIVE;
            val_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            val_q   <= val_d;
        end
    end

    // outputs
    always_comb begin
        code_out   = val_q;
        code_drive = (state_q == OUT_DRIVE);
    end

    // R9: release lasts exactly one clock
    a_r9_gap_single: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(code_drive) |=> code_drive);

    // R9: driven value changes only across a release
    a_r9_change_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (code_drive && !$stable(code_out)) |-> !$past(code_drive));

    // R10: matching value keeps the pin driven
    a_r10_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (code_drive && target == code_out) |=> code_drive);

endmodule

// File: rtl/pn_code_pair.sv
module pn_code_pair #(
    parameter int STAGES = 13,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free_stb,
    input  logic              phase_stb,
    input  logic              is_master,
    input  logic              force_load,
    input  logic              resync,
    input  logic [STAGES-1:0] tx_poly,
    input  logic [STAGES-1:0] rx_poly,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              tx_half,
    input  logic              out_en,
    output logic              code_out,
    output logic              code_drive,
    output logic              tx_epoch,
    output logic              rx_epoch
);

    logic tx_step;
    logic rx_step;
    logic tx_bit;
    logic rx_bit;

    // stepping source: master runs transmit free, slave locks both to phase
    assign tx_step = is_master ? free_stb : phase_stb;
    assign rx_step = phase_stb;

    pn_lfsr_gen #(.STAGES(STAGES), .LEN_W(LEN_W)) u_tx_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_cfg (force_load),
        .restart  (resync),
        .step     (tx_step),
        .poly_in  (tx_poly),
        .len_in   (tx_len),
        .code_bit (tx_bit),
        .epoch    (tx_epoch)
    );

    pn_lfsr_gen #(.STAGES(STAGES), .LEN_W(LEN_W)) u_rx_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_cfg (force_load),
        .restart  (resync),
        .step     (rx_step),
        .poly_in  (rx_poly),
        .len_in   (rx_len),
        .code_bit (rx_bit),
        .epoch    (rx_epoch)
    );

    pn_out_mux u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_bit     (tx_bit),
        .rx_bit     (rx_bit),
        .tx_half    (tx_half),
        .out_en     (out_en),
        .code_out   (code_out),
        .code_drive (code_drive)
    );

    // R7: in slave mode the free strobe alone moves neither generator
    a_r7_slave_free_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !phase_stb && !force_load && !resync)
            |=> ($stable(tx_bit) && $stable(rx_bit) && $stable(tx_epoch) && $stable(rx_epoch)));

    // R6: a restart command raises both epochs together
    a_r6_both_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (force_load || resync) |=> (tx_epoch && rx_epoch));

endmodule

// File: tb/pn_code_pair_tb.sv
module pn_code_pair_tb;

    localparam int ST = 13;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          free_stb = 1'b0;
    logic          phase_stb = 1'b0;
    logic          is_master = 1'b1;
    logic          force_load = 1'b0;
    logic          resync = 1'b0;
    logic [ST-1:0] tx_poly = '0;
    logic [ST-1:0] rx_poly = '0;
    logic [LW-1:0] tx_len = '0;
    logic [LW-1:0] rx_len = '0;
    logic          tx_half = 1'b0;
    logic          out_en = 1'b0;
    logic          code_out;
    logic          code_drive;
    logic          tx_epoch;
    logic          rx_epoch;

    always #2 clk = ~clk;

    pn_code_pair #(.STAGES(ST), .LEN_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .free_stb(free_stb), .phase_stb(phase_stb),
        .is_master(is_master), .force_load(force_load), .resync(resync),
        .tx_poly(tx_poly), .rx_poly(rx_poly), .tx_len(tx_len), .rx_len(rx_len),
        .tx_half(tx_half), .out_en(out_en), .code_out(code_out),
        .code_drive(code_drive), .tx_epoch(tx_epoch), .rx_epoch(rx_epoch)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic  code;
        logic  txe;
        logic  rxe;
        string req;
    } exp_t;

    exp_t q[$];
    event mon_ev;

    // reference model state
    logic [ST-1:0] m_tx_s = '1, m_rx_s = '1;
    logic [ST-1:0] m_tx_c = '0, m_rx_c = '0;
    logic [ST-1:0] m_tx_p = '0, m_rx_p = '0;
    logic [LW-1:0] m_tx_l = '0, m_rx_l = '0;

    function automatic logic [ST-1:0] act(input logic [LW-1:0] l);
        return {l, {(ST-LW){1'b1}}};
    endfunction

    function automatic logic top_bit(input logic [ST-1:0] s, input logic [LW-1:0] l);
        logic [ST-1:0] m;
        logic b;
        m = act(l);
        b = 1'b0;
        for (int i = 0; i < ST; i++) if (m[i]) b = s[i];
        return b;
    endfunction

    task automatic m_step(inout logic [ST-1:0] s, inout logic [ST-1:0] c,
                          input logic [ST-1:0] p, input logic [LW-1:0] l);
        logic [ST-1:0] m;
        m = act(l);
        if (&(c | ~m)) begin
            s = '1;
            c = '0;
        end else begin
            s = {s[ST-2:0], ^(s & p & m)};
            c = c + 1'b1;
        end
    endtask

    function automatic logic exp_code();
        if (!out_en) return 1'b0;
        return tx_half ? top_bit(m_tx_s, m_tx_l) : top_bit(m_rx_s, m_rx_l);
    endfunction

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
        n_tests++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // driver side of the scoreboard: queue expectation, let output settle, hand off
    task automatic push_and_wait(input string req);
        q.push_back('{exp_code(), (m_tx_c == '0), (m_rx_c == '0), req});
        repeat (4) @(negedge clk);
        ->mon_ev;
    endtask

    task automatic chip(input logic f, input logic p, input string req);
        @(negedge clk);
        free_stb  = f;
        phase_stb = p;
        @(negedge clk);
        free_stb  = 1'b0;
        phase_stb = 1'b0;
        if (is_master ? f : p) m_step(m_tx_s, m_tx_c, m_tx_p, m_tx_l);
        if (p) m_step(m_rx_s, m_rx_c, m_rx_p, m_rx_l);
        push_and_wait(req);
    endtask

    task automatic do_load(input string req);
        @(negedge clk);
        force_load = 1'b1;
        @(negedge clk);
        force_load = 1'b0;
        m_tx_p = tx_poly; m_rx_p = rx_poly;
        m_tx_l = tx_len;  m_rx_l = rx_len;
        m_tx_s = '1; m_rx_s = '1; m_tx_c = '0; m_rx_c = '0;
        push_and_wait(req);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(mon_ev);
            if (q.size() == 0) begin
                chk("scoreboard empty", 0, 1);
            end else begin
                exp_t it;
                it = q.pop_front();
                chk({it.req, " code_out"},   code_out,   it.code);
                chk({it.req, " code_drive"}, code_drive, 1);
                chk({it.req, " tx_epoch"},   tx_epoch,   it.txe);
                chk({it.req, " rx_epoch"},   rx_epoch,   it.rxe);
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 code_drive", code_drive, 1);
        chk("R1 code_out", code_out, 0);
        chk("R1 tx_epoch", tx_epoch, 1);
        chk("R1 rx_epoch", rx_epoch, 1);

        // R8: enabling the output with reset config shows transmit start bit
        out_en = 1'b1;
        tx_half = 1'b1;
        @(negedge clk);
        push_and_wait("R8");

        // R5: load short codes
        tx_poly = 13'h0030;
        rx_poly = 13'h0061;
        tx_len  = 8'h01;
        rx_len  = 8'h03;
        do_load("R5 load");

        // R2 R3 R4: transmit 64-chip period, free strobe in master
        for (int i = 0; i < 70; i++) chip(1'b1, 1'b0, "R2 R3 R4 tx");

        // R7: free strobe leaves receive code alone in master mode
        tx_half = 1'b0;
        @(negedge clk);
        push_and_wait("R8 rx half");
        for (int i = 0; i < 5; i++) chip(1'b1, 1'b0, "R7 master free");

        // R2 R4: receive 128-chip period on phase strobe
        for (int i = 0; i < 132; i++) chip(1'b0, 1'b1, "R2 R4 rx");

        // R5: polynomial and mask inputs ignored without load
        rx_poly = 13'h1FFF;
        rx_len  = 8'hFF;
        for (int i = 0; i < 10; i++) chip(1'b0, 1'b1, "R5 ignored");

        // R6: resync restarts both, keeps config
        @(negedge clk);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        m_tx_s = '1; m_rx_s = '1; m_tx_c = '0; m_rx_c = '0;
        push_and_wait("R6 resync");

        // R7: slave mode, free strobe does nothing
        is_master = 1'b0;
        tx_half = 1'b1;
        @(negedge clk);
        push_and_wait("R7 slave");
        for (int i = 0; i < 5; i++) chip(1'b1, 1'b0, "R7 slave free");
        for (int i = 0; i < 20; i++) chip(1'b0, 1'b1, "R7 slave phase");

        // R6: resync wins over a simultaneous step
        @(negedge clk);
        resync = 1'b1;
        phase_stb = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        phase_stb = 1'b0;
        m_tx_s = '1; m_rx_s = '1; m_tx_c = '0; m_rx_c = '0;
        push_and_wait("R6 priority");

        // R6: force_load wins over resync and takes new config
        tx_poly = 13'h0030;
        rx_poly = 13'h0030;
        tx_len  = 8'h01;
        rx_len  = 8'h01;
        @(negedge clk);
        resync = 1'b1;
        force_load = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        force_load = 1'b0;
        m_tx_p = tx_poly; m_rx_p = rx_poly; m_tx_l = tx_len; m_rx_l = rx_len;
        m_tx_s = '1; m_rx_s = '1; m_tx_c = '0; m_rx_c = '0;
        push_and_wait("R6 load priority");

        // R10: both codes equal (1), toggling tx_half keeps pin driven
        for (int i = 0; i < 6; i++) begin
            tx_half = ~tx_half;
            @(negedge clk);
            chk("R10 drive held on match", code_drive, 1);
            chk("R10 value held on match", code_out, 1);
        end

        // R9: disabling output changes value 1 -> 0 with one-clock release
        out_en = 1'b0;
        @(negedge clk);
        chk("R9 released", code_drive, 0);
        @(negedge clk);
        chk("R9 driven again", code_drive, 1);
        chk("R9 new value", code_out, 0);
        @(negedge clk);
        chk("R9 single gap", code_drive, 1);

        // R10: output disabled, phase toggles do not release
        for (int i = 0; i < 6; i++) begin
            tx_half = ~tx_half;
            @(negedge clk);
            chk("R10 disabled drive", code_drive, 1);
            chk("R8 disabled low", code_out, 0);
        end

        // R2 R4: full 8192-chip transmit period
        is_master = 1'b1;
        tx_half = 1'b1;
        out_en = 1'b1;
        tx_poly = 13'h1B00;
        tx_len  = 8'hFF;
        do_load("R5 long load");
        for (int i = 0; i < 8194; i++) chip(1'b1, 1'b0, "R2 R4 long");

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule